// File: doc/BRIEF.md
# PTP One-Step Egress Timestamp Inserter

This block sits in the transmit path of an Ethernet MAC, ahead of FCS generation. A byte-wide frame stream passes through it with a fixed delay, and the block can rewrite fields inside a frame to perform IEEE 1588 one-step operations. The controls for each frame are taken from the beat that carries both valid and start-of-packet. Per frame, the block can do one of two things. It can write the egress time of day into a timestamp field at a given byte offset. Or it can add the residence time into the 8-octet correction field, where the residence time is the egress time of day minus an ingress time supplied with the frame.

Every byte waits in a delay line of `LAT` stages. By the time the first byte of a frame leaves the block, the whole frame has arrived, so its length is known. A request that is illegal or that points past the end of the frame leaves the frame untouched and raises an error flag on its last output beat. Downstream ready is wired straight back upstream, and the delay line advances only while ready is high. The block never inserts bubbles of its own. The 96-bit time value is laid out as 48 bits of seconds, 32 bits of nanoseconds and 16 bits of fractional nanoseconds, from the most significant bit down.

Top module: `ptp1s_inserter`

## Requirements
- R1: With no operation requested, every frame leaves byte-for-byte unchanged. Start and end markers keep their positions. With downstream ready held high, a beat accepted at an input clock edge is accepted at the output exactly `LAT` clock edges later. Frames of a single beat are included.
- R2: The controls (`ctl_stamp`, `ctl_corr`, `ctl_fmt_v1`, `ctl_ts_off`, `ctl_cf_off`, `ctl_ingress_tod`) are used only from the beat where `s_valid` and `s_sop` are both high. Changing them on later beats of the frame has no effect on that frame.
- R3: With `ctl_stamp=1` and `ctl_fmt_v1=0`, the 10 octets starting at byte `ctl_ts_off` receive time bits [95:16], most significant octet first. Octet 0 is the first destination address octet. Octets `ctl_cf_off+6` and `ctl_cf_off+7` receive time bits [15:8] and [7:0]. All other bytes, including offset 0 as a field start, follow this rule with no other changes.
- R4: With `ctl_stamp=1` and `ctl_fmt_v1=1`, the 8 octets starting at `ctl_ts_off` receive time bits [79:16], most significant octet first. The correction field is not touched.
- R5: The time of day used for a frame is the value of `tod` on its start-of-packet beat. Changes to `tod` during the rest of the frame do not alter the inserted bytes.
- R6: With `ctl_corr=1` and `ctl_fmt_v1=0`, the 8 big-endian octets at `ctl_cf_off` are replaced by their old value plus the residence time, modulo 2^64. The residence time is zero-extended to 64 bits and equals (`tod[47:0]` − `ctl_ingress_tod[47:0]`) modulo 2^48.
- R7: A frame requesting both `ctl_stamp` and `ctl_corr` leaves the block unmodified and is flagged with `m_err`.
- R8: A frame requesting `ctl_corr` with `ctl_fmt_v1=1` leaves the block unmodified and is flagged with `m_err`.
- R9: If any field that the request writes does not end at or before the last byte of the frame, the frame leaves unmodified and is flagged with `m_err`. This covers the timestamp field, the low correction octets for format 0, and the correction field. A field that ends exactly on the last byte is legal.
- R10: `m_err` is high only together with `m_valid` and `m_eop`, and only for a frame that R7, R8 or R9 rejects.
- R11: While `rst_n` is low, `m_valid` is low.
- R12: `s_ready` follows `m_ready`. While `m_valid` is high and `m_ready` is low, the output beat holds steady. Frames sent back to back each use their own controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input beat valid |
| s_sop | input | 1 | Input first byte of frame |
| s_eop | input | 1 | Input last byte of frame |
| s_data | input | 8 | Input byte |
| s_ready | output | 1 | Upstream may transfer (equals `m_ready`) |
| ctl_stamp | input | 1 | Write egress time into the timestamp field |
| ctl_corr | input | 1 | Add residence time into the correction field |
| ctl_fmt_v1 | input | 1 | 0: 80-bit timestamp layout, 1: 64-bit layout |
| ctl_ts_off | input | 16 | Byte offset of the timestamp field |
| ctl_cf_off | input | 16 | Byte offset of the correction field |
| ctl_ingress_tod | input | 96 | Ingress time of the frame |
| tod | input | 96 | Current time of day |
| m_valid | output | 1 | Output beat valid |
| m_sop | output | 1 | Output first byte of frame |
| m_eop | output | 1 | Output last byte of frame |
| m_data | output | 8 | Output byte |
| m_err | output | 1 | Frame rejected; high on its last beat |
| m_ready | input | 1 | Downstream accepts a beat |

## Verification
Several kinds of work can land on the same clock edge. The capture side may be latching the controls and time of day of a new frame, or pushing a finished frame's record. In that same cycle, the patch side may be popping the record of an older frame and rewriting its bytes. Both sides also run at once whenever ready stalls freeze the line. The bench provokes this overlap by sending frames back to back under a random ready pattern, including a single-beat frame. It also changes the controls and `tod` in the middle of a frame. A scoreboard compares every output byte, marker and error bit against frames predicted from the requirements, so a record that goes to the wrong frame, or a value latched on the wrong beat, shows up as a corrupted frame.

// File: rtl/ptp1s_pkg.sv
package ptp1s_pkg;

  localparam int OFF_W      = 16;
  localparam int TOD_W      = 96;
  localparam int RES_W      = 48;
  localparam int CF_BYTES   = 8;
  localparam int TS_V2_BYTES = 10;
  localparam int TS_V1_BYTES = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_STAMP = 2'd1,
    OP_CORR  = 2'd2
  } op_e;

  typedef struct packed {
    logic              vld;
    logic              sop;
    logic              eop;
    logic [7:0]        data;
  } beat_t;

  typedef struct packed {
    logic              err;
    op_e               op;
    logic              v1;
    logic [OFF_W-1:0]  ts_off;
    logic [OFF_W-1:0]  cf_off;
    logic [TOD_W-1:0]  stamp;
    logic [8*CF_BYTES-1:0] cf_val;
  } rec_t;

endpackage

// File: rtl/ptp1s_beat_delay.sv
module ptp1s_beat_delay
  import ptp1s_pkg::*;
#(
  parameter int LAT = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  beat_t beat_in,
  output beat_t beat_out
);

  beat_t stage [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    beat_t src;
    if (i == 0) begin : g_head
      assign src = beat_in;
    end else begin : g_body
      assign src = stage[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[i] <= '0;
      end else if (adv) begin
        stage[i] <= src;
      end
    end
  end

  assign beat_out = stage[LAT-1];

endmodule

// File: rtl/ptp1s_rec_fifo.sv
module ptp1s_rec_fifo
  import ptp1s_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  rec_t din,
  input  logic pop,
  output rec_t dout
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rec_t          mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];

endmodule

// File: rtl/ptp1s_ingress_capture.sv
module ptp1s_ingress_capture
  import ptp1s_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sop,
  input  logic             eop,
  input  logic [7:0]       data,
  input  logic             ins_ts,
  input  logic             ins_cf,
  input  logic             fmt_v1,
  input  logic [OFF_W-1:0] ts_off,
  input  logic [OFF_W-1:0] cf_off,
  input  logic [TOD_W-1:0] its,
  input  logic [TOD_W-1:0] tod,
  output logic             push,
  output rec_t             rec
);

  localparam int CF_W = 8 * CF_BYTES;

  logic             q_ts, q_cf, q_v1;
  logic [OFF_W-1:0] q_tsoff, q_cfoff, q_idx;
  logic [TOD_W-1:0] q_stamp;
  logic [RES_W-1:0] q_res;
  logic [CF_W-1:0]  q_cfb;

  logic             e_ts, e_cf, e_v1;
  logic [OFF_W-1:0] e_tsoff, e_cfoff, e_idx;
  logic [TOD_W-1:0] e_stamp;
  logic [RES_W-1:0] e_res;
  logic [CF_W-1:0]  cf_nxt;
  logic [OFF_W:0]   len, ts_end, cf_end;
  logic             bad;

  always_comb begin
    e_ts    = sop ? ins_ts : q_ts;
    e_cf    = sop ? ins_cf : q_cf;
    e_v1    = sop ? fmt_v1 : q_v1;
    e_tsoff = sop ? ts_off : q_tsoff;
    e_cfoff = sop ? cf_off : q_cfoff;
    e_stamp = sop ? tod    : q_stamp;
    e_res   = sop ? (tod[RES_W-1:0] - its[RES_W-1:0]) : q_res;
    e_idx   = sop ? '0     : q_idx;

    cf_nxt = sop ? '0 : q_cfb;
    for (int j = 0; j < CF_BYTES; j++) begin
      if ({1'b0, e_idx} == {1'b0, e_cfoff} + (OFF_W+1)'(j))
        cf_nxt[CF_W-1-8*j -: 8] = data;
    end

    len    = {1'b0, e_idx} + 1'b1;
    ts_end = {1'b0, e_tsoff} + (e_v1 ? (OFF_W+1)'(TS_V1_BYTES) : (OFF_W+1)'(TS_V2_BYTES));
    cf_end = {1'b0, e_cfoff} + (OFF_W+1)'(CF_BYTES);

    bad = (e_ts && e_cf) ||
          (e_cf && e_v1) ||
          (e_ts && ((ts_end > len) || (!e_v1 && (cf_end > len)))) ||
          (e_cf && (cf_end > len));

    rec.err    = bad;
    rec.op     = bad  ? OP_NONE  :
                 e_ts ? OP_STAMP :
                 e_cf ? OP_CORR  : OP_NONE;
    rec.v1     = e_v1;
    rec.ts_off = e_tsoff;
    rec.cf_off = e_cfoff;
    rec.stamp  = e_stamp;
    rec.cf_val = cf_nxt + {{(CF_W-RES_W){1'b0}}, e_res};

    push = take && eop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ts    <= 1'b0;
      q_cf    <= 1'b0;
      q_v1    <= 1'b0;
      q_tsoff <= '0;
      q_cfoff <= '0;
      q_idx   <= '0;
      q_stamp <= '0;
      q_res   <= '0;
      q_cfb   <= '0;
    end else if (take) begin
      q_ts    <= e_ts;
      q_cf    <= e_cf;
      q_v1    <= e_v1;
      q_tsoff <= e_tsoff;
      q_cfoff <= e_cfoff;
      q_idx   <= e_idx + 1'b1;
      q_stamp <= e_stamp;
      q_res   <= e_res;
      q_cfb   <= cf_nxt;
    end
  end

endmodule

// File: rtl/ptp1s_egress_patch.sv
module ptp1s_egress_patch
  import ptp1s_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  beat_t      tail,
  input  rec_t       head,
  output logic       pop,
  output logic [7:0] data_o,
  output logic       err_o
);

  localparam int CF_W = 8 * CF_BYTES;

  rec_t             act_q, act;
  logic [OFF_W-1:0] pos_q, pos;
  logic [OFF_W:0]   p;

  always_comb begin
    act    = tail.sop ? head : act_q;
    pos    = tail.sop ? '0   : pos_q;
    p      = {1'b0, pos};
    data_o = tail.data;

    unique case (act.op)
      OP_STAMP: begin
        if (!act.v1) begin
          if (p == {1'b0, act.cf_off} + (OFF_W+1)'(CF_BYTES-2)) data_o = act.stamp[15:8];
          if (p == {1'b0, act.cf_off} + (OFF_W+1)'(CF_BYTES-1)) data_o = act.stamp[7:0];
        end
        for (int j = 0; j < TS_V2_BYTES; j++) begin
          if (p == {1'b0, act.ts_off} + (OFF_W+1)'(j)) begin
            if (!act.v1)
              data_o = act.stamp[TOD_W-1-8*j -: 8];
            else if (j < TS_V1_BYTES)
              data_o = act.stamp[TOD_W-17-8*j -: 8];
          end
        end
      end
      OP_CORR: begin
        for (int j = 0; j < CF_BYTES; j++) begin
          if (p == {1'b0, act.cf_off} + (OFF_W+1)'(j))
            data_o = act.cf_val[CF_W-1-8*j -: 8];
        end
      end
      default: ;
    endcase

    err_o = tail.vld && tail.eop && act.err;
    pop   = fire && tail.sop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      pos_q <= '0;
    end else if (fire) begin
      act_q <= act;
      pos_q <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/ptp1s_inserter.sv
module ptp1s_inserter
  import ptp1s_pkg::*;
#(
  parameter int LAT    = 64,
  parameter int FRAMES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_sop,
  input  logic              s_eop,
  input  logic [7:0]        s_data,
  output logic              s_ready,
  input  logic              ctl_stamp,
  input  logic              ctl_corr,
  input  logic              ctl_fmt_v1,
  input  logic [15:0]       ctl_ts_off,
  input  logic [15:0]       ctl_cf_off,
  input  logic [95:0]       ctl_ingress_tod,
  input  logic [95:0]       tod,
  output logic              m_valid,
  output logic              m_sop,
  output logic              m_eop,
  output logic [7:0]        m_data,
  output logic              m_err,
  input  logic              m_ready
);

  beat_t beat_in, tail;
  rec_t  rec_in, rec_head;
  logic  take, push, pop, fire;

  assign s_ready = m_ready;
  assign take    = s_valid && m_ready;
  assign beat_in = '{vld: s_valid, sop: s_sop, eop: s_eop, data: s_data};
  assign fire    = tail.vld && m_ready;

  ptp1s_ingress_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .sop    (s_sop),
    .eop    (s_eop),
    .data   (s_data),
    .ins_ts (ctl_stamp),
    .ins_cf (ctl_corr),
    .fmt_v1 (ctl_fmt_v1),
    .ts_off (ctl_ts_off),
    .cf_off (ctl_cf_off),
    .its    (ctl_ingress_tod),
    .tod    (tod),
    .push   (push),
    .rec    (rec_in)
  );

  ptp1s_rec_fifo #(.DEPTH(FRAMES)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (rec_in),
    .pop   (pop),
    .dout  (rec_head)
  );

  ptp1s_beat_delay #(.LAT(LAT)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (m_ready),
    .beat_in  (beat_in),
    .beat_out (tail)
  );

  ptp1s_egress_patch u_patch (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .tail   (tail),
    .head   (rec_head),
    .pop    (pop),
    .data_o (m_data),
    .err_o  (m_err)
  );

  assign m_valid = tail.vld;
  assign m_sop   = tail.vld && tail.sop;
  assign m_eop   = tail.vld && tail.eop;

endmodule

// File: rtl/ptp1s_inserter_chk.sv
module ptp1s_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       m_valid,
  input logic       m_ready,
  input logic       m_sop,
  input logic       m_eop,
  input logic       m_err,
  input logic [7:0] m_data
);

  logic out_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_busy <= 1'b0;
    end else if (m_valid && m_ready) begin
      out_busy <= !m_eop;
    end
  end

  assert_err_on_eop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (m_valid && m_eop));

  assert_err_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> !m_err);

  assert_hold_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_eop)));

  assert_hold_sop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(m_sop));

  assert_no_nested_sop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_sop) |-> !out_busy);

endmodule

bind ptp1s_inserter ptp1s_inserter_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_sop   (m_sop),
  .m_eop   (m_eop),
  .m_err   (m_err),
  .m_data  (m_data)
);

// File: tb/tb_ptp1s_inserter.sv
module tb_ptp1s_inserter;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 64;
  localparam int FRAMES     = 16;

  logic        clk, rst_n;
  logic        s_valid, s_sop, s_eop, s_ready;
  logic [7:0]  s_data;
  logic        ctl_stamp, ctl_corr, ctl_fmt_v1;
  logic [15:0] ctl_ts_off, ctl_cf_off;
  logic [95:0] ctl_ingress_tod, tod;
  logic        m_valid, m_sop, m_eop, m_err, m_ready;
  logic [7:0]  m_data;

  ptp1s_inserter #(.LAT(LAT), .FRAMES(FRAMES)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_sop(s_sop), .s_eop(s_eop), .s_data(s_data), .s_ready(s_ready),
    .ctl_stamp(ctl_stamp), .ctl_corr(ctl_corr), .ctl_fmt_v1(ctl_fmt_v1),
    .ctl_ts_off(ctl_ts_off), .ctl_cf_off(ctl_cf_off),
    .ctl_ingress_tod(ctl_ingress_tod), .tod(tod),
    .m_valid(m_valid), .m_sop(m_sop), .m_eop(m_eop), .m_data(m_data),
    .m_err(m_err), .m_ready(m_ready)
  );

  int        checks, fails, cyc, sop_in_cyc;
  bit        rand_ready, lat_pending, done;
  logic [10:0] expq[$];
  string       tagq[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // downstream ready pattern
  initial m_ready = 1'b1;
  always @(negedge clk) begin
    #1;
    m_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // driver: builds the expected frame, then drives it
  task automatic send_frame(input int len, input bit st, input bit co, input bit v1,
                            input int tsoff, input int cfoff,
                            input logic [95:0] its, input logic [95:0] t0,
                            input bit scramble, input int seed, input string tag,
                            input bit probe);
    logic [7:0]  fb [64];
    logic [7:0]  eb [64];
    logic [63:0] cfo;
    logic [47:0] res;
    bit          bad;
    int          tslen;
    for (int k = 0; k < 64; k++) begin
      fb[k] = 8'((seed * 13) + (k * 29) + 7);
      eb[k] = fb[k];
    end
    tslen = v1 ? 8 : 10;
    bad = (st && co) || (co && v1) ||
          (st && ((tsoff + tslen > len) || (!v1 && (cfoff + 8 > len)))) ||
          (co && (cfoff + 8 > len));
    if (!bad && st) begin
      if (!v1) begin
        eb[cfoff+6] = t0[15:8];
        eb[cfoff+7] = t0[7:0];
      end
      for (int j = 0; j < tslen; j++)
        eb[tsoff+j] = v1 ? t0[79-8*j -: 8] : t0[95-8*j -: 8];
    end
    if (!bad && co) begin
      cfo = '0;
      for (int j = 0; j < 8; j++) cfo = {cfo[55:0], fb[cfoff+j]};
      res = t0[47:0] - its[47:0];
      cfo = cfo + {16'h0, res};
      for (int j = 0; j < 8; j++) eb[cfoff+j] = cfo[63-8*j -: 8];
    end
    for (int k = 0; k < len; k++)
      expq.push_back({(k == 0), (bad && (k == len-1)), (k == len-1), eb[k]});
    tagq.push_back(tag);

    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_sop   = (k == 0);
      s_eop   = (k == len-1);
      s_data  = fb[k];
      if (k == 0) begin
        ctl_stamp = st; ctl_corr = co; ctl_fmt_v1 = v1;
        ctl_ts_off = 16'(tsoff); ctl_cf_off = 16'(cfoff);
        ctl_ingress_tod = its; tod = t0;
      end else if (scramble) begin
        ctl_stamp = !st; ctl_corr = !co; ctl_fmt_v1 = !v1;
        ctl_ts_off = 16'($urandom % 8); ctl_cf_off = 16'($urandom % 8);
        ctl_ingress_tod = ~its; tod = ~t0;
      end
      #3;
      while (!s_ready) begin
        @(negedge clk);
        #3;
      end
      if (k == 0 && probe) sop_in_cyc = cyc + 1;
    end
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
  endtask

  // monitor / scoreboard
  int          midx;
  bit          fbad;
  logic [10:0] f_act, f_exp;
  initial begin midx = 0; fbad = 1'b0; f_act = '0; f_exp = '0; end

  always @(negedge clk) begin
    #3;
    if (rst_n && m_valid && m_ready) begin
      logic [10:0] a, e;
      a = {m_sop, m_err, m_eop, m_data};
      if (lat_pending && m_sop) begin
        lat_pending = 1'b0;
        chk((cyc + 1 - sop_in_cyc) == LAT, "R1 latency", 64'(cyc + 1 - sop_in_cyc), 64'(LAT));
      end
      if (expq.size() == 0) begin
        chk(1'b0, "R1 unexpected output beat", 64'(a), 64'h0);
      end else begin
        e = expq.pop_front();
        if (a !== e && !fbad) begin
          fbad = 1'b1; f_act = a; f_exp = e;
        end
        midx++;
        if (e[8]) begin
          chk(!fbad, (tagq.size() != 0) ? tagq.pop_front() : "R1 frame", 64'(f_act), 64'(f_exp));
          fbad = 1'b0; midx = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  localparam logic [95:0] TA = {48'h0000_1234_5678, 32'h1122_3344, 16'hA5C3};
  localparam logic [95:0] TB = {48'h0000_0000_0042, 32'h0000_0010, 16'h8000};
  localparam logic [95:0] IA = {48'h0000_1234_5670, 32'h1122_0000, 16'h0001};
  localparam logic [95:0] IB = {48'h0000_0000_0041, 32'h0000_0020, 16'h4000};

  initial begin
    checks = 0; fails = 0; done = 1'b0; rand_ready = 1'b0; lat_pending = 1'b0;
    rst_n = 1'b0; s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_data = '0;
    ctl_stamp = 1'b0; ctl_corr = 1'b0; ctl_fmt_v1 = 1'b0;
    ctl_ts_off = '0; ctl_cf_off = '0; ctl_ingress_tod = '0; tod = '0;
    sop_in_cyc = 0;
    repeat (3) @(negedge clk);
    #3;
    chk(m_valid == 1'b0, "R11 reset output idle", 64'(m_valid), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    lat_pending = 1'b1;
    send_frame(40, 0, 0, 0, 0, 0, '0, TA, 0, 1, "R1 plain frame", 1);
    send_frame(44, 1, 0, 0, 22, 8, '0, TA, 0, 2, "R3 v2 stamp", 0);
    send_frame(40, 1, 0, 1, 30, 0, '0, TB, 0, 3, "R4 v1 stamp", 0);
    send_frame(40, 0, 1, 0, 0, 10, IA, TB, 0, 4, "R6 correction wrapped residence", 0);
    send_frame(40, 0, 1, 0, 0, 24, IB, TB, 0, 5, "R6 correction with carry", 0);
    send_frame(40, 1, 1, 0, 5, 20, IA, TA, 0, 6, "R7 R10 both requested", 0);
    send_frame(40, 0, 1, 1, 0, 12, IA, TA, 0, 7, "R8 R10 correction with v1", 0);
    send_frame(40, 1, 0, 1, 35, 0, '0, TA, 0, 8, "R9 timestamp past end", 0);
    send_frame(40, 1, 0, 0, 10, 34, '0, TA, 0, 9, "R9 correction low octets past end", 0);
    send_frame(40, 1, 0, 1, 32, 0, '0, TB, 0, 10, "R9 field ends on last byte", 0);
    send_frame(48, 1, 0, 0, 14, 30, '0, TA, 1, 11, "R2 R5 controls and tod latched at sop", 0);
    send_frame(18, 1, 0, 0, 0, 10, '0, TB, 0, 12, "R3 timestamp at offset zero", 0);
    send_frame(1, 0, 0, 0, 0, 0, '0, TA, 0, 13, "R1 single beat frame", 0);
    rand_ready = 1'b1;
    send_frame(36, 0, 1, 0, 0, 4, IB, TA, 0, 14, "R12 stalled correction frame", 0);
    send_frame(30, 1, 0, 0, 6, 18, '0, TB, 1, 15, "R12 stalled stamp frame", 0);
    send_frame(1, 0, 0, 0, 0, 0, '0, TB, 0, 16, "R12 stalled single beat", 0);
    send_frame(20, 1, 1, 0, 0, 8, IA, TA, 0, 17, "R12 R7 stalled rejected frame", 0);
    rand_ready = 1'b0;

    for (int w = 0; w < 4 * LAT && expq.size() != 0; w++) @(negedge clk);
    #5;
    chk(expq.size() == 0, "R12 all frames delivered", 64'(expq.size()), 64'h0);
    summary();
  end

endmodule